// File: doc/BRIEF.md
# Status LED Pattern Sequencer

This block drives one status LED bit. During normal operation it shows one of four patterns, picked by a two-bit request from the device status logic: steady off, steady on, slow flashing at 1 Hz or fast flashing at 8 Hz. Both flashing patterns have a 50% duty cycle. All timing comes from one prescaler. The prescaler divides the system clock into a base half-period of 1/16 s, so each flash level lasts an exact whole number of clock cycles.

Before normal display starts, the block gives a power-on indication. A strap input picks which one, and the block reads that strap on the first clock after reset is released. With the strap low, auto-activation is on, and the LED flashes at 8 Hz for at least half a second while activation is tried. The burst ends at the first half-period boundary at which the minimum length has passed and activation success is reported. If success never comes, the burst ends after a bounded number of half-periods, and the LED then shows the requested pattern. With the strap high, no activation is tried: the LED is held off for one second as a sign of life, and then shows the requested pattern.

Top module: `status_led_seq`

## Requirements
In this list, edge k means the k-th rising clock edge after `rstN` goes high, where edge 0 is the first one. H is the fast half-period, equal to CLK_HZ/16 cycles. "Flash starting high" means the LED is high for H (or 8H) cycles, then low for the same number of cycles, and so on, starting right after the edge that starts the pattern.

- R1: While `rstN` is low, `ledOut` is 0. `autoActStrap` is sampled at edge 0.
- R2: In normal display, `modeReq` 2'b00 holds `ledOut` at 0 and 2'b01 holds it at 1.
- R3: In normal display, `modeReq` 2'b11 gives a flash starting high, with each level lasting H cycles.
- R4: In normal display, `modeReq` 2'b10 gives a flash starting high, with each level lasting 8H cycles (0.5 s).
- R5: A change of `modeReq` that is sampled at an edge loads the new pattern's first level at that same edge: 0 for 2'b00, 1 for any other code. The flash phase restarts there, so the first level after the change has its full length.
- R6: A strap of 1 at edge 0 holds `ledOut` at 0 after edges 0 through 16H-1 (1 s), whatever `actDone` does. The requested pattern starts at edge 16H.
- R7: A strap of 0 at edge 0 starts an 8 Hz burst that begins high at edge 0. At the edge that completes half-period n, the burst ends if n is at least 8 and `actDone` is 1. The requested pattern then starts at that same edge.
- R8: If `actDone` is never seen at such an edge, the burst ends at the edge that completes half-period BURST_MAX_TICKS, and the requested pattern starts there.
- R9: After edge 0, changes of `autoActStrap` have no effect on `ledOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| autoActStrap | input | 1 | Power-on strap: 0 means activation burst, 1 means one-second off indication |
| modeReq | input | 2 | Requested display pattern: 00 off, 01 on, 10 1 Hz, 11 8 Hz |
| actDone | input | 1 | Activation-success flag, read at burst half-period boundaries |
| ledOut | output | 1 | LED drive bit |

## Verification
The output is a registered bit whose value at every cycle follows from the edge count since reset release. So a wrong phase counter, prescaler count or sequencer state appears as a wrong `ledOut` level within one half-period at most: H cycles for the fast pattern and the burst, 8H cycles for the slow pattern. An error in the power-on choice or in burst termination appears at edge 0 or at the boundary where the burst should have ended. The bench compares every cycle of each scenario against levels computed from edge counts, so the first wrong cycle is reported.

// File: rtl/ledseq_pkg.sv
package ledseq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ON   = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_FAST = 2'b11
  } ledMode_t;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_BURST,
    ST_LIFE,
    ST_SHOW
  } seqState_t;

  // Strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic restart;    // clear prescaler and tick counter
    logic clrTicks;   // clear tick counter only
    logic load;       // load LED with loadLevel
    logic loadLevel;
    logic toggle;     // invert LED
  } ledStrobe_t;

  function automatic logic startLevel(ledMode_t m);
    return (m != MODE_OFF);
  endfunction

endpackage

// File: rtl/ledseq_datapath.sv
module ledseq_datapath
  import ledseq_pkg::*;
#(
  parameter int HALF_CYC = 100,
  parameter int TICK_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ledStrobe_t        strobe,
  output logic              tick,
  output logic [TICK_W-1:0] tickCount,
  output logic              led
);

  generate
    if (HALF_CYC <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PRE_W = $clog2(HALF_CYC);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(HALF_CYC - 1);
      logic [PRE_W-1:0] preCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (strobe.restart || preCnt == PRE_LAST) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign tick = (preCnt == PRE_LAST);
    end
  endgenerate

  // Half-periods completed since the last phase restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (strobe.restart || strobe.clrTicks) begin
      tickCount <= '0;
    end else if (tick && tickCount != '1) begin
      tickCount <= tickCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      led <= 1'b0;
    end else if (strobe.load) begin
      led <= strobe.loadLevel;
    end else if (strobe.toggle) begin
      led <= ~led;
    end
  end

endmodule

// File: rtl/ledseq_control.sv
module ledseq_control
  import ledseq_pkg::*;
#(
  parameter int TICK_W          = 6,
  parameter int BURST_MIN_TICKS = 8,
  parameter int BURST_MAX_TICKS = 32,
  parameter int LIFE_TICKS      = 16,
  parameter int SLOW_TICKS      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapIn,
  input  logic              actOk,
  input  logic [1:0]        modeIn,
  input  logic              tick,
  input  logic [TICK_W-1:0] tickCount,
  output ledStrobe_t        strobe,
  output seqState_t         seqState,
  output ledMode_t          modeQ
);

  localparam int CW = TICK_W + 1;
  localparam logic [CW-1:0] MIN_N  = CW'(BURST_MIN_TICKS);
  localparam logic [CW-1:0] MAX_N  = CW'(BURST_MAX_TICKS);
  localparam logic [CW-1:0] LIFE_N = CW'(LIFE_TICKS);
  localparam logic [CW-1:0] SLOW_N = CW'(SLOW_TICKS);

  seqState_t     stateD;
  ledMode_t      modeD;
  ledMode_t      modeReqT;
  logic [CW-1:0] doneTicks;
  logic          enterShow;

  assign modeReqT  = ledMode_t'(modeIn);
  assign doneTicks = {1'b0, tickCount} + CW'(1);

  always_comb begin
    stateD    = seqState;
    modeD     = modeQ;
    strobe    = '0;
    enterShow = 1'b0;
    unique case (seqState)
      ST_BOOT: begin
        strobe.restart   = 1'b1;
        strobe.load      = 1'b1;
        strobe.loadLevel = ~strapIn;
        stateD           = strapIn ? ST_LIFE : ST_BURST;
      end
      ST_BURST: begin
        if (tick) begin
          if ((doneTicks >= MIN_N && actOk) || doneTicks >= MAX_N) begin
            enterShow = 1'b1;
          end else begin
            strobe.toggle = 1'b1;
          end
        end
      end
      ST_LIFE: begin
        if (tick && doneTicks >= LIFE_N) begin
          enterShow = 1'b1;
        end
      end
      ST_SHOW: begin
        if (modeReqT != modeQ) begin
          enterShow = 1'b1;
        end else if (tick) begin
          unique case (modeQ)
            MODE_FAST: begin
              strobe.toggle   = 1'b1;
              strobe.clrTicks = 1'b1;
            end
            MODE_SLOW: begin
              if (doneTicks >= SLOW_N) begin
                strobe.toggle   = 1'b1;
                strobe.clrTicks = 1'b1;
              end
            end
            default: strobe.clrTicks = 1'b1;
          endcase
        end
      end
      default: stateD = ST_BOOT;
    endcase

    if (enterShow) begin
      stateD           = ST_SHOW;
      modeD            = modeReqT;
      strobe.restart   = 1'b1;
      strobe.load      = 1'b1;
      strobe.loadLevel = startLevel(modeReqT);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= ST_BOOT;
      modeQ    <= MODE_OFF;
    end else begin
      seqState <= stateD;
      modeQ    <= modeD;
    end
  end

endmodule

// File: rtl/status_led_seq.sv
module status_led_seq
  import ledseq_pkg::*;
#(
  parameter int CLK_HZ          = 1600,
  parameter int BURST_MAX_TICKS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoActStrap,
  input  logic [1:0] modeReq,
  input  logic       actDone,
  output logic       ledOut
);

  localparam int TICKS_PER_SEC   = 16;
  localparam int HALF_CYC        = CLK_HZ / TICKS_PER_SEC;
  localparam int BURST_MIN_TICKS = TICKS_PER_SEC / 2;
  localparam int LIFE_TICKS      = TICKS_PER_SEC;
  localparam int SLOW_TICKS      = TICKS_PER_SEC / 2;
  localparam int TICK_LIMIT      = (BURST_MAX_TICKS > LIFE_TICKS) ? BURST_MAX_TICKS : LIFE_TICKS;
  localparam int TICK_W          = $clog2(TICK_LIMIT + 1);

  ledStrobe_t        strobe;
  logic              tick;
  logic [TICK_W-1:0] tickCount;
  seqState_t         seqState;
  ledMode_t          modeQ;

  ledseq_control #(
    .TICK_W         (TICK_W),
    .BURST_MIN_TICKS(BURST_MIN_TICKS),
    .BURST_MAX_TICKS(BURST_MAX_TICKS),
    .LIFE_TICKS     (LIFE_TICKS),
    .SLOW_TICKS     (SLOW_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strapIn  (autoActStrap),
    .actOk    (actDone),
    .modeIn   (modeReq),
    .tick     (tick),
    .tickCount(tickCount),
    .strobe   (strobe),
    .seqState (seqState),
    .modeQ    (modeQ)
  );

  ledseq_datapath #(
    .HALF_CYC(HALF_CYC),
    .TICK_W  (TICK_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tick     (tick),
    .tickCount(tickCount),
    .led      (ledOut)
  );

endmodule

// File: rtl/status_led_seq_chk.sv
module status_led_seq_chk
  import ledseq_pkg::*;
#(
  parameter int HALF_CYC        = 100,
  parameter int BURST_MIN_TICKS = 8,
  parameter int BURST_MAX_TICKS = 32
) (
  input logic      clk,
  input logic      rstN,
  input logic      led,
  input logic      tick,
  input seqState_t seqState,
  input ledMode_t  modeQ
);

  localparam int MIN_CYC = BURST_MIN_TICKS * HALF_CYC;
  localparam int MAX_CYC = BURST_MAX_TICKS * HALF_CYC;

  int burstCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstCyc <= 0;
    end else if (seqState == ST_BURST) begin
      burstCyc <= burstCyc + 1;
    end else begin
      burstCyc <= 0;
    end
  end

  assert_boot_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_BOOT |-> !led);

  assert_steady_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_SHOW && modeQ == MODE_OFF) |-> !led);

  assert_steady_on_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_SHOW && modeQ == MODE_ON) |-> led);

  assert_quiet_between_ticks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_SHOW && $past(seqState) == ST_SHOW && $stable(modeQ) && !$past(tick))
      |-> $stable(led));

  assert_life_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_LIFE |-> !led);

  assert_burst_min_R7: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_BURST |=> (seqState == ST_BURST || burstCyc >= MIN_CYC));

  assert_burst_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    seqState == ST_BURST |-> burstCyc < MAX_CYC);

  assert_no_reboot_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqState != ST_BOOT |=> seqState != ST_BOOT);

endmodule

bind status_led_seq status_led_seq_chk #(
  .HALF_CYC       (CLK_HZ / 16),
  .BURST_MIN_TICKS(8),
  .BURST_MAX_TICKS(BURST_MAX_TICKS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .led     (ledOut),
  .tick    (tick),
  .seqState(seqState),
  .modeQ   (modeQ)
);

// File: tb/status_led_seq_tb.sv
`timescale 1ns/1ps
module status_led_seq_tb;

  localparam int CLK_HZ = 1600;
  localparam int H      = CLK_HZ / 16;
  localparam int BMAX   = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       autoActStrap = 1'b0;
  logic [1:0] modeReq = 2'b00;
  logic       actDone = 1'b0;
  logic       ledOut;

  int checkCount = 0;
  int failCount  = 0;
  bit    expVal[$];
  string expTag[$];

  always #2 clk = ~clk;

  status_led_seq #(.CLK_HZ(CLK_HZ), .BURST_MAX_TICKS(BMAX)) u_dut (
    .clk(clk), .rstN(rstN), .autoActStrap(autoActStrap),
    .modeReq(modeReq), .actDone(actDone), .ledOut(ledOut)
  );

  task automatic pushLevel(bit v, int n, string tag);
    for (int i = 0; i < n; i++) begin
      expVal.push_back(v);
      expTag.push_back(tag);
    end
  endtask

  task automatic pushFlash(int half, int n, string tag);
    for (int i = 0; i < n; i++) begin
      expVal.push_back(((i / half) % 2) == 0);
      expTag.push_back(tag);
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetDut(bit strap, logic [1:0] mode, bit act);
    @(negedge clk);
    rstN = 1'b0;
    waitNeg(4);
    checkCount++;
    if (ledOut !== 1'b0) begin
      failCount++;
      $display("FAIL R1 reset level: ledOut=%0b expected 0", ledOut);
    end
    autoActStrap = strap;
    modeReq = mode;
    actDone = act;
  endtask

  task automatic drain();
    wait (expVal.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: compare one expected level per cycle after each rising edge
  always @(posedge clk) begin
    #1;
    if (expVal.size() != 0) begin
      bit e;
      string t;
      e = expVal.pop_front();
      t = expTag.pop_front();
      checkCount++;
      if (ledOut !== e) begin
        failCount++;
        $display("FAIL %s: ledOut=%0b expected %0b at %0t", t, ledOut, e, $time);
      end
    end
  end

  initial begin
    #(200000 * 4);
    failCount++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    // Scenario A: strap high, sign of life, then mode changes
    resetDut(1'b1, 2'b01, 1'b1);
    rstN = 1'b1;
    pushLevel(1'b0, 16 * H, "R6 life low");
    pushLevel(1'b1, 50, "R2 steady high");
    pushFlash(H, 4 * H + 30, "R3 R5 fast after change");
    pushFlash(8 * H, 20 * H, "R4 R5 R9 slow after change");
    pushLevel(1'b0, 60, "R2 R5 steady low");
    waitNeg(800);
    autoActStrap = 1'b0;      // R9: ignored during life
    waitNeg(850);             // negedge after edge 1649
    modeReq = 2'b11;
    waitNeg(430);             // negedge after edge 2079, mid-phase
    modeReq = 2'b10;
    waitNeg(700);
    autoActStrap = 1'b1;      // R9: ignored in normal display
    actDone = 1'b0;
    waitNeg(1300);            // negedge after edge 4079
    modeReq = 2'b00;
    drain();

    // Scenario B: strap low, success present, burst ends at minimum
    resetDut(1'b0, 2'b10, 1'b1);
    rstN = 1'b1;
    pushFlash(H, 8 * H, "R7 burst minimum");
    pushFlash(8 * H, 17 * H, "R4 R7 slow after success");
    waitNeg(300);
    autoActStrap = 1'b1;      // R9: ignored during burst
    drain();

    // Scenario C: success reported later, burst ends at next boundary
    resetDut(1'b0, 2'b01, 1'b0);
    rstN = 1'b1;
    pushFlash(H, 11 * H, "R7 burst until success");
    pushLevel(1'b1, 100, "R2 R7 steady high after success");
    waitNeg(10 * H + 6);
    actDone = 1'b1;
    drain();

    // Scenario D: no success, burst runs to its maximum
    resetDut(1'b0, 2'b00, 1'b0);
    rstN = 1'b1;
    pushFlash(H, BMAX * H, "R8 burst to maximum");
    pushLevel(1'b0, 100, "R2 R8 steady low after timeout");
    pushFlash(H, 250, "R3 fast flash");
    waitNeg(BMAX * H + 100);
    modeReq = 2'b11;
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule